// File: doc/BRIEF.md
# Bidirectional Signed-Count Barrel Shifter

The block shifts a 40-bit operand by a distance and a direction taken from one signed count. It returns the result one clock after a start strobe. Accumulator operations use the full 40-bit value. A positive count gives an arithmetic right shift, a negative count gives a left shift that fills the low bits with zeros, and a count of zero passes the value through.

Word operations work on the low 16 bits of the operand. The operation select chooses arithmetic right, logical right or left, and the count supplies only the magnitude.

The count is also checked against the accumulator limit of sixteen positions. An accumulator request outside that range still produces a shifted value. It also raises an error flag that nothing can mask, and it holds the accumulator write-enable low, so a downstream accumulator file keeps its old contents.

Top module: `bishift_unit`

## Requirements
- R1: `valid_o` is high in exactly the cycle after a cycle with `start_i` high, and low otherwise.
- R2: With `op_i`=0 (accumulator) and `count_i` from 1 to 31, `acc_result_o` is `operand_i` shifted right arithmetically by that count, with bit 39 copied into the vacated upper bits.
- R3: With `op_i`=0 and a negative `count_i` (6-bit two's complement, -1 to -32), `acc_result_o` is `operand_i` shifted left by the magnitude. Zeros fill the low bits, and bits moved past bit 39 are lost.
- R4: A count of zero returns the operand unchanged: all 40 bits on `acc_result_o` for `op_i`=0, and the low 16 bits on `word_result_o` for word operations.
- R5: An accumulator operation with a count above +16 or below -16 sets `range_err_o` and clears `acc_we_o` in its result cycle. `acc_result_o` still shows the shift by the full count.
- R6: An accumulator operation with a count from -16 to +16 sets `acc_we_o` and clears `range_err_o` in its result cycle.
- R7: Word operations take `operand_i[15:0]` and the magnitude of `count_i`. `op_i`=1 shifts right arithmetically, `op_i`=2 shifts right with zero fill, and `op_i`=3 shifts left with zero fill.
- R8: For a word magnitude above 15, the logical right and left shifts give zero, and the arithmetic right shift gives sixteen copies of bit 15.
- R9: A word operation never raises `acc_we_o` or `range_err_o` and leaves `acc_result_o` unchanged. An accumulator operation leaves `word_result_o` unchanged.
- R10: While `rst_ni` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept an operation this cycle |
| op_i | input | 2 | 0 accumulator, 1 word arithmetic right, 2 word logical right, 3 word left |
| count_i | input | 6 | Signed shift count |
| operand_i | input | 40 | Value to shift; word operations use bits 15:0 |
| valid_o | output | 1 | Result strobe, one cycle after start |
| acc_result_o | output | 40 | Accumulator shift result |
| word_result_o | output | 16 | Word shift result |
| acc_we_o | output | 1 | Accumulator write-enable for the result cycle |
| range_err_o | output | 1 | Accumulator count out of range |

## Verification
The hardest case to reach is the edge of the range check. A count of exactly ±16 must write back, while ±17 and the extreme codes +31 and -32 must raise the error, withhold the write and still show the shifted value. The vector table places these counts next to each other, with operands of both signs so that the sign fill is visible. Back-to-back starts then alternate accumulator and word operations, which confirms that each result port keeps its value across operations of the other kind.

// File: rtl/bishift_pkg.sv
package bishift_pkg;
  localparam int unsigned ACC_W     = 40;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned CNT_W     = 6;
  localparam int unsigned ACC_LIMIT = 16;

  typedef enum logic [1:0] {
    OP_ACC  = 2'd0,
    OP_WASR = 2'd1,
    OP_WLSR = 2'd2,
    OP_WSL  = 2'd3
  } op_e;
endpackage

// File: rtl/bishift_core.sv
// Logarithmic right shifter; left shifts reuse it through bit reversal.
module bishift_core #(
  parameter int unsigned W     = 40,
  parameter int unsigned MAG_W = 6
) (
  input  logic [W-1:0]     data_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             left_i,
  input  logic             fill_i,
  output logic [W-1:0]     data_o
);
  logic [W-1:0]         rev_in, rev_out;
  logic [MAG_W:0][W-1:0] stage;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = data_i[W-1-i];
    assign rev_out[i] = stage[MAG_W][W-1-i];
  end

  assign stage[0] = left_i ? rev_in : data_i;

  for (genvar k = 0; k < MAG_W; k++) begin : g_stage
    localparam int unsigned SH = 1 << k;
    if (SH >= W) begin : g_full
      assign stage[k+1] = mag_i[k] ? {W{fill_i}} : stage[k];
    end else begin : g_part
      assign stage[k+1] = mag_i[k] ? {{SH{fill_i}}, stage[k][W-1:SH]} : stage[k];
    end
  end

  assign data_o = left_i ? rev_out : stage[MAG_W];
endmodule

// File: rtl/bishift_range.sv
module bishift_range #(
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned MAX_SHIFT = 16
) (
  input  logic [CNT_W-1:0] count_i,
  output logic             neg_o,
  output logic [CNT_W-1:0] mag_o,
  output logic             over_o
);
  assign neg_o  = count_i[CNT_W-1];
  // most negative code maps to its unsigned magnitude (e.g. -32 -> 32)
  assign mag_o  = neg_o ? (~count_i + 1'b1) : count_i;
  assign over_o = mag_o > CNT_W'(MAX_SHIFT);
endmodule

// File: rtl/bishift_word.sv
module bishift_word
  import bishift_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned MAG_W = 6
) (
  input  op_e              op_i,
  input  logic [W-1:0]     data_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic [W-1:0]     data_o
);
  logic left, fill;

  assign left = (op_i == OP_WSL);
  assign fill = (op_i == OP_WASR) & data_i[W-1];

  bishift_core #(.W(W), .MAG_W(MAG_W)) u_core (
    .data_i (data_i),
    .mag_i  (mag_i),
    .left_i (left),
    .fill_i (fill),
    .data_o (data_o)
  );
endmodule

// File: rtl/bishift_unit.sv
module bishift_unit
  import bishift_pkg::*;
#(
  parameter int unsigned AW    = ACC_W,
  parameter int unsigned WW    = WORD_W,
  parameter int unsigned CW    = CNT_W,
  parameter int unsigned LIMIT = ACC_LIMIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [CW-1:0] count_i,
  input  logic [AW-1:0] operand_i,
  output logic          valid_o,
  output logic [AW-1:0] acc_result_o,
  output logic [WW-1:0] word_result_o,
  output logic          acc_we_o,
  output logic          range_err_o
);
  op_e           op;
  logic          neg, over, is_acc;
  logic [CW-1:0] mag;
  logic [AW-1:0] acc_shift;
  logic [WW-1:0] word_shift;

  assign op     = op_e'(op_i);
  assign is_acc = (op == OP_ACC);

  bishift_range #(.CNT_W(CW), .MAX_SHIFT(LIMIT)) u_range (
    .count_i (count_i),
    .neg_o   (neg),
    .mag_o   (mag),
    .over_o  (over)
  );

  bishift_core #(.W(AW), .MAG_W(CW)) u_acc (
    .data_i (operand_i),
    .mag_i  (mag),
    .left_i (neg),
    .fill_i (~neg & operand_i[AW-1]),
    .data_o (acc_shift)
  );

  bishift_word #(.W(WW), .MAG_W(CW)) u_word (
    .op_i   (op),
    .data_i (operand_i[WW-1:0]),
    .mag_i  (mag),
    .data_o (word_shift)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o       <= 1'b0;
      acc_we_o      <= 1'b0;
      range_err_o   <= 1'b0;
      acc_result_o  <= '0;
      word_result_o <= '0;
    end else begin
      valid_o     <= start_i;
      acc_we_o    <= start_i & is_acc & ~over;
      range_err_o <= start_i & is_acc & over;
      if (start_i & is_acc)  acc_result_o  <= acc_shift;
      if (start_i & ~is_acc) word_result_o <= word_shift;
    end
  end

  assert_valid_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  assert_valid_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);
  assert_err_blocks_we_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_err_o |-> !acc_we_o && valid_o);
  assert_zero_passthru_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && is_acc && count_i == '0) |=> acc_result_o == $past(operand_i));
  assert_word_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !is_acc) |=> !acc_we_o && !range_err_o && $stable(acc_result_o));
  assert_acc_keeps_word_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && is_acc) |=> $stable(word_result_o));
  assert_edge_writes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && is_acc && (count_i == CW'(LIMIT) || count_i == CW'(-LIMIT))) |=> acc_we_o);
endmodule

// File: tb/bishift_unit_bench.sv
module bishift_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 22;

  typedef struct packed {
    logic [1:0]  op;
    logic [5:0]  cnt;
    logic [39:0] data;
    logic        err;
  } vec_t;

  // op: 0 acc, 1 word asr, 2 word lsr, 3 word sl
  localparam vec_t [0:N-1] VECS = '{
    '{2'd0, 6'h00, 40'h80_1234_5678, 1'b0},  // R4
    '{2'd0, 6'h01, 40'h80_1234_5678, 1'b0},  // R2
    '{2'd0, 6'h05, 40'h7F_FFFF_FFFF, 1'b0},  // R2
    '{2'd0, 6'h10, 40'h80_1234_5678, 1'b0},  // R2 R6 edge
    '{2'd0, 6'h11, 40'h80_1234_5678, 1'b1},  // R5
    '{2'd0, 6'h1F, 40'hC0_0000_0001, 1'b1},  // R5 extreme
    '{2'd0, 6'h3F, 40'hC0_1234_5678, 1'b0},  // R3
    '{2'd0, 6'h38, 40'h00_0000_00A5, 1'b0},  // R3
    '{2'd0, 6'h30, 40'h12_3456_789A, 1'b0},  // R3 R6 edge
    '{2'd0, 6'h2F, 40'h12_3456_789A, 1'b1},  // R5
    '{2'd0, 6'h20, 40'hFF_FFFF_FFA5, 1'b1},  // R5 extreme
    '{2'd1, 6'h03, 40'h00_0000_8421, 1'b0},  // R7
    '{2'd2, 6'h03, 40'h00_0000_8421, 1'b0},  // R7
    '{2'd3, 6'h03, 40'h00_0000_8421, 1'b0},  // R7
    '{2'd1, 6'h0F, 40'h00_0000_8421, 1'b0},  // R7
    '{2'd3, 6'h31, 40'h00_0000_0001, 1'b0},  // R7 -15 magnitude
    '{2'd1, 6'h10, 40'h00_0000_8421, 1'b0},  // R8
    '{2'd1, 6'h2C, 40'h00_0000_4421, 1'b0},  // R8
    '{2'd2, 6'h10, 40'h00_0000_FFFF, 1'b0},  // R8
    '{2'd3, 6'h1F, 40'h00_0000_FFFF, 1'b0},  // R8
    '{2'd2, 6'h00, 40'hAB_CDEF_1357, 1'b0},  // R4 word
    '{2'd0, 6'h08, 40'h01_0000_0000, 1'b0}   // R2
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [5:0]  count_i = '0;
  logic [39:0] operand_i = '0;
  logic        valid_o, acc_we_o, range_err_o;
  logic [39:0] acc_result_o;
  logic [15:0] word_result_o;

  int total = 0;
  int bad = 0;
  logic [39:0] exp_acc = '0;
  logic [15:0] exp_word = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bishift_unit u_bishift_unit (
    .clk_i, .rst_ni, .start_i, .op_i, .count_i, .operand_i,
    .valid_o, .acc_result_o, .word_result_o, .acc_we_o, .range_err_o
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input logic [1:0] op, input logic [5:0] cnt, input logic [39:0] d);
    int c, m;
    c = $signed(cnt);
    m = (c < 0) ? -c : c;
    case (op)
      2'd0: exp_acc = (c >= 0) ? 40'($signed(d) >>> m) : 40'(d << m);
      2'd1: exp_word = 16'($signed(d[15:0]) >>> m);
      2'd2: exp_word = 16'(d[15:0] >> m);
      default: exp_word = 16'(d[15:0] << m);
    endcase
  endtask

  // drive on a falling edge, check on the next falling edge
  task automatic issue(input vec_t v, input logic keep_start);
    @(negedge clk_i);
    start_i = 1'b1; op_i = v.op; count_i = v.cnt; operand_i = v.data;
    model(v.op, v.cnt, v.data);
    @(negedge clk_i);
    if (!keep_start) start_i = 1'b0;
    check("R1 valid", 64'(valid_o), 64'd1);
    check("R2/R3/R4/R5/R9 acc_result", 64'(acc_result_o), 64'(exp_acc));
    check("R7/R8/R4/R9 word_result", 64'(word_result_o), 64'(exp_word));
    check("R5/R6/R9 acc_we", 64'(acc_we_o), 64'(v.op == 2'd0 && !v.err));
    check("R5/R9 range_err", 64'(range_err_o), 64'(v.err));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10 reset state
    operand_i = 40'hFF_FFFF_FFFF; count_i = 6'h05; start_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R10 valid", 64'(valid_o), 64'd0);
    check("R10 acc_result", 64'(acc_result_o), 64'd0);
    check("R10 word_result", 64'(word_result_o), 64'd0);
    check("R10 flags", 64'({acc_we_o, range_err_o}), 64'd0);
    start_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle", 64'(valid_o), 64'd0);

    for (int i = 0; i < N; i++) issue(VECS[i], 1'b0);

    // R1 back to back, alternating kinds (R9 holding)
    issue('{2'd0, 6'h02, 40'h80_0000_0000, 1'b0}, 1'b1);
    issue('{2'd2, 6'h04, 40'h00_0000_F0F0, 1'b0}, 1'b1);
    issue('{2'd0, 6'h3C, 40'h00_0000_000F, 1'b0}, 1'b0);

    // R1 valid drops after idle cycle
    @(negedge clk_i);
    check("R1 drop", 64'(valid_o), 64'd0);
    check("R6 we idle", 64'(acc_we_o), 64'd0);
    check("R9 acc held", 64'(acc_result_o), 64'(exp_acc));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule